// File: doc/BRIEF.md
# Desaturation Fault Sequencer

This block supervises short-circuit protection for a single power switch. It takes the filtered drive request and a digitised flag from an external comparator. The flag is high when the collector sense voltage is above its trip level. In normal operation the gate-on command follows the drive request one cycle later.

Each time the request turns on, the comparator is ignored for a blanking window. After that window the comparator has to stay high without a break for a qualification window before a fault is declared. A confirmed fault does four things:

- It drops the gate-on command at once.
- It asserts a soft turn-off command for a fixed time.
- It pulls the active-low fault flag low after a delay.
- It mutes the drive request for a long hold-off time.

The fault stays latched until an active-low clear input has been held low for a minimum number of samples and then returns high. The clear is only accepted once the mute time has run out. Every time constant is a cycle count. The defaults assume a 100 MHz clock: 450 ns blanking, 320 ns qualification, 2.6 us soft turn-off, 450 ns flag delay, 5 ms mute and an 800 ns minimum clear pulse.

Top module: `desat_sequencer`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `gate_on`=0, `soft_off`=0, `fault_n`=1 and `mute`=0.
- R2: With no fault latched, `gate_on` equals the value `drive_req` had at the previous clock edge.
- R3: During the first BLANK_CYC clock edges at which `drive_req` is sampled high after being low, the value of `desat_hit` has no effect.
- R4: A fault is declared at the edge where `desat_hit` has been sampled high on FILT_CYC consecutive edges after blanking. A shorter run restarts the count and declares nothing.
- R5: From the fault edge onward `gate_on` is 0, and `soft_off` is 1 for exactly STO_CYC cycles.
- R6: `fault_n` goes low exactly FLT_DLY_CYC cycles after the fault edge.
- R7: `mute` is 1 for exactly MUTE_CYC cycles after the fault edge. While it is high, `drive_req` has no effect on `gate_on`.
- R8: If `mute` is 0, `flt_rst_n` sampled low on at least RST_MIN_CYC consecutive edges and then sampled high clears the fault. `fault_n` is 1 right after that edge.
- R9: A low pulse on `flt_rst_n` shorter than RST_MIN_CYC samples, or one that ends while `mute` is 1, leaves `fault_n` at 0.
- R10: `gate_on` stays 0 while the fault is latched. After a clear, a request that is still held high goes through a fresh blanking window before the comparator counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| drive_req | input | 1 | Filtered drive request |
| desat_hit | input | 1 | Digitised comparator flag, high when over threshold |
| flt_rst_n | input | 1 | Fault clear input, active low |
| gate_on | output | 1 | Normal gate-on command |
| soft_off | output | 1 | Soft turn-off command |
| fault_n | output | 1 | Latched fault flag, active low |
| mute | output | 1 | Input mute window active |

## Verification
The bench builds the block with blanking 6, qualification 4, soft turn-off 20, flag delay 6, mute 200 and minimum clear 8 cycles. With these values the bench can run a whole mute window while checking every cycle against the exact edges it computed for each output. The small windows also bring the off-by-one boundaries within reach in a few hundred cycles. These are a comparator run one sample short of the filter, a clear pulse one sample short of the minimum, and a clear attempted inside the mute window.

// File: rtl/desat_pkg.sv
package desat_pkg;
  // Width needed to hold values 0..n
  function automatic int cnt_w(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/desat_qual.sv
module desat_qual
  import desat_pkg::*;
#(
  parameter int BLANK_CYC = 45,
  parameter int FILT_CYC  = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic drive_req,
  input  logic desat_hit,
  output logic confirm
);
  localparam int BW = cnt_w(BLANK_CYC);
  localparam int FW = cnt_w(FILT_CYC);

  logic [BW-1:0] on_cnt;
  logic [FW-1:0] filt_cnt;
  logic          armed;

  assign armed = (on_cnt == BW'(BLANK_CYC));

  // Blanking: counts request-high samples, restarts whenever request drops
  always_ff @(posedge clk) begin
    if (rst || hold || !drive_req) on_cnt <= '0;
    else if (!armed)               on_cnt <= on_cnt + 1'b1;
  end

  // Qualification: consecutive armed, high comparator samples
  always_ff @(posedge clk) begin
    if (rst || hold || !armed || !desat_hit) filt_cnt <= '0;
    else if (filt_cnt != FW'(FILT_CYC - 1))  filt_cnt <= filt_cnt + 1'b1;
  end

  assign confirm = !hold && armed && desat_hit && (filt_cnt == FW'(FILT_CYC - 1));
endmodule

// File: rtl/desat_timer.sv
module desat_timer
  import desat_pkg::*;
#(
  parameter int LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic last
);
  localparam int W = cnt_w(LEN);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)           cnt <= '0;
    else if (start)    cnt <= W'(LEN);
    else if (cnt != 0) cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != 0);
  assign last = (cnt == W'(1));
endmodule

// File: rtl/desat_clr_width.sv
module desat_clr_width
  import desat_pkg::*;
#(
  parameter int RST_MIN_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic lvl_n,
  output logic release_ok
);
  localparam int W = cnt_w(RST_MIN_CYC);
  logic [W-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (rst || lvl_n)                   low_cnt <= '0;
    else if (low_cnt != W'(RST_MIN_CYC)) low_cnt <= low_cnt + 1'b1;
  end

  // Rising sample after a long enough low run
  assign release_ok = lvl_n && (low_cnt == W'(RST_MIN_CYC));
endmodule

// File: rtl/desat_sequencer.sv
module desat_sequencer
  import desat_pkg::*;
#(
  parameter int BLANK_CYC   = 45,
  parameter int FILT_CYC    = 32,
  parameter int STO_CYC     = 260,
  parameter int FLT_DLY_CYC = 45,
  parameter int MUTE_CYC    = 500000,
  parameter int RST_MIN_CYC = 80
) (
  input  logic clk,
  input  logic rst,
  input  logic drive_req,
  input  logic desat_hit,
  input  logic flt_rst_n,
  output logic gate_on,
  output logic soft_off,
  output logic fault_n,
  output logic mute
);
  logic fault_lat;
  logic confirm;
  logic clr_ok;
  logic clr;
  logic sto_busy, sto_last;
  logic dly_busy, dly_last;
  logic mute_busy, mute_last;

  desat_qual #(.BLANK_CYC(BLANK_CYC), .FILT_CYC(FILT_CYC)) u_qual (
    .clk(clk), .rst(rst), .hold(fault_lat),
    .drive_req(drive_req), .desat_hit(desat_hit), .confirm(confirm)
  );

  desat_timer #(.LEN(STO_CYC)) u_sto (
    .clk(clk), .rst(rst), .start(confirm), .busy(sto_busy), .last(sto_last)
  );

  desat_timer #(.LEN(FLT_DLY_CYC)) u_dly (
    .clk(clk), .rst(rst), .start(confirm), .busy(dly_busy), .last(dly_last)
  );

  desat_timer #(.LEN(MUTE_CYC)) u_mute (
    .clk(clk), .rst(rst), .start(confirm), .busy(mute_busy), .last(mute_last)
  );

  desat_clr_width #(.RST_MIN_CYC(RST_MIN_CYC)) u_clr (
    .clk(clk), .rst(rst), .lvl_n(flt_rst_n), .release_ok(clr_ok)
  );

  assign clr = fault_lat && clr_ok && !mute_busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault_lat <= 1'b0;
      fault_n   <= 1'b1;
      gate_on   <= 1'b0;
    end else begin
      gate_on <= drive_req && !fault_lat && !confirm;
      if (confirm)  fault_lat <= 1'b1;
      else if (clr) fault_lat <= 1'b0;
      if (clr)           fault_n <= 1'b1;
      else if (dly_last) fault_n <= 1'b0;
    end
  end

  assign soft_off = sto_busy;
  assign mute     = mute_busy;
endmodule

// File: rtl/desat_sequencer_chk.sv
module desat_sequencer_chk (
  input logic clk,
  input logic rst,
  input logic drive_req,
  input logic desat_hit,
  input logic flt_rst_n,
  input logic gate_on,
  input logic soft_off,
  input logic fault_n,
  input logic mute
);
  AST_GATE_LOW_IN_FAULT: assert property (@(posedge clk) disable iff (rst)
    !fault_n |-> !gate_on); // R10

  AST_SOFT_EXCL_GATE: assert property (@(posedge clk) disable iff (rst)
    soft_off |-> !gate_on); // R5

  AST_SOFT_ON_GATE_DROP: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_off) |-> $fell(gate_on)); // R5

  AST_MUTE_WITH_FAULT: assert property (@(posedge clk) disable iff (rst)
    $rose(soft_off) |-> $rose(mute)); // R7

  AST_NO_CLEAR_IN_MUTE: assert property (@(posedge clk) disable iff (rst)
    (mute && !fault_n) |=> !fault_n); // R9

  AST_CLEAR_NEEDS_PULSE: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_n) |-> ($past(flt_rst_n) && !$past(flt_rst_n, 2))); // R8
endmodule

bind desat_sequencer desat_sequencer_chk u_chk (
  .clk(clk), .rst(rst), .drive_req(drive_req), .desat_hit(desat_hit),
  .flt_rst_n(flt_rst_n), .gate_on(gate_on), .soft_off(soft_off),
  .fault_n(fault_n), .mute(mute)
);

// File: tb/desat_sequencer_tb.sv
`timescale 1ns/1ps
module desat_sequencer_tb;
  localparam int B = 6;
  localparam int F = 4;
  localparam int S = 20;
  localparam int D = 6;
  localparam int M = 200;
  localparam int RM = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic drive_req = 1'b0;
  logic desat_hit = 1'b0;
  logic flt_rst_n = 1'b1;
  logic gate_on, soft_off, fault_n, mute;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  desat_sequencer #(
    .BLANK_CYC(B), .FILT_CYC(F), .STO_CYC(S),
    .FLT_DLY_CYC(D), .MUTE_CYC(M), .RST_MIN_CYC(RM)
  ) u_dut (
    .clk(clk), .rst(rst), .drive_req(drive_req), .desat_hit(desat_hit),
    .flt_rst_n(flt_rst_n), .gate_on(gate_on), .soft_off(soft_off),
    .fault_n(fault_n), .mute(mute)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic t_reset;
    step(3);
    chk("R1 gate_on", gate_on, 1'b0);
    chk("R1 soft_off", soft_off, 1'b0);
    chk("R1 fault_n", fault_n, 1'b1);
    chk("R1 mute", mute, 1'b0);
    rst = 1'b0;
    step(1);
    chk("R1 gate_on after release", gate_on, 1'b0);
    chk("R1 fault_n after release", fault_n, 1'b1);
  endtask

  task automatic t_follow;
    drive_req = 1'b1;
    step(1);
    chk("R2 gate rises one cycle later", gate_on, 1'b1);
    drive_req = 1'b0;
    step(1);
    chk("R2 gate falls one cycle later", gate_on, 1'b0);
    drive_req = 1'b1;
    step(3);
    chk("R2 gate held", gate_on, 1'b1);
    drive_req = 1'b0;
    step(2);
  endtask

  task automatic t_blank;
    // comparator high exactly over the blanking samples, then low
    drive_req = 1'b1;
    desat_hit = 1'b1;
    step(B);
    desat_hit = 1'b0;
    step(10);
    chk("R3 no fault from blanked samples", fault_n, 1'b1);
    chk("R3 gate still on", gate_on, 1'b1);
    chk("R3 no soft_off", soft_off, 1'b0);
    drive_req = 1'b0;
    step(2);
  endtask

  task automatic t_filter;
    drive_req = 1'b1;
    step(B + 2);
    desat_hit = 1'b1; step(F - 1);
    desat_hit = 1'b0; step(1);
    desat_hit = 1'b1; step(F - 1);
    desat_hit = 1'b0; step(8);
    chk("R4 short runs restart filter", fault_n, 1'b1);
    chk("R4 gate kept", gate_on, 1'b1);
    chk("R4 no soft_off", soft_off, 1'b0);
    drive_req = 1'b0;
    step(2);
  endtask

  task automatic t_fault_seq;
    logic eg, es, ef, em;
    drive_req = 1'b1;
    desat_hit = 1'b1;
    for (int k = 1; k <= M + 15; k++) begin
      step(1);
      eg = (k < B + F);
      es = (k >= B + F) && (k < B + F + S);
      ef = !(k >= B + F + D);
      em = (k >= B + F) && (k < B + F + M);
      chk("R5/R10 gate_on", gate_on, eg);
      chk("R5 soft_off window", soft_off, es);
      chk("R6 fault_n delay", fault_n, ef);
      chk("R7 mute window", mute, em);
      // early clear pulse inside mute window (R9)
      flt_rst_n = !(k >= 30 && k < 42);
      // request toggling during mute is ignored (R7)
      drive_req = !(k >= 50 && k < 60);
    end
    desat_hit = 1'b0;
    flt_rst_n = 1'b1;
  endtask

  task automatic t_clear_rules;
    flt_rst_n = 1'b0; step(RM - 1);
    flt_rst_n = 1'b1; step(3);
    chk("R9 short pulse keeps fault", fault_n, 1'b0);
    chk("R10 gate low while latched", gate_on, 1'b0);
    flt_rst_n = 1'b0; step(RM);
    flt_rst_n = 1'b1;
    desat_hit = 1'b1;
    step(1);
    chk("R8 fault released", fault_n, 1'b1);
    chk("R8 gate still low on clear edge", gate_on, 1'b0);
    step(1);
    chk("R10 gate resumes after clear", gate_on, 1'b1);
    step(B + F - 2);
    chk("R10 fresh blanking after clear", gate_on, 1'b1);
    step(1);
    chk("R4 fault after blank plus filter", gate_on, 1'b0);
    chk("R5 soft_off on refault", soft_off, 1'b1);
    step(D - 1);
    chk("R6 flag not yet", fault_n, 1'b1);
    step(1);
    chk("R6 flag asserted", fault_n, 1'b0);
    desat_hit = 1'b0;
    drive_req = 1'b0;
  endtask

  initial begin
    t_reset();
    t_follow();
    t_blank();
    t_filter();
    t_fault_seq();
    t_clear_rules();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule